// File: doc/BRIEF.md
# Compare-Match 8-bit PWM Channel

This block is one output channel of a programmable counter array. A shared free-running timebase is counted outside the channel. The channel receives the low byte of that count and a one-cycle strobe that marks the low byte wrapping from its all-ones value to zero.

The channel holds a working compare byte and a shadow duty byte. When the count equals the working compare byte, a registered output is set. The wrap strobe clears the output. The same strobe copies the shadow byte into the working compare byte, so a new duty value written part-way through a period takes effect only from the next period. With a shadow value of H, the output is high for 256 − H cycles of each 256-cycle period. A shadow value of zero gives a constant high output.

Software reaches the channel through a small synchronous byte port with an address, a write strobe, write data and combinational read data. Writing the working compare byte turns compare off. Writing the shadow byte turns compare back on. For this reason a full 16-bit load writes the working byte first and the shadow byte second.

Top module: `pwm8_channel`

## Requirements
- R1: The channel is active only when mode bit 0 (compare enable) and mode bit 1 (PWM select) are both 1. While it is inactive, the output is low from the next edge on and the working compare byte is not reloaded at a wrap.
- R2: While the channel is active, a count equal to the working compare byte with no wrap strobe sets the output at that clock edge. The output then stays high until a wrap.
- R3: While the channel is active and the shadow byte is nonzero, a wrap strobe drives the output low at that edge. This takes priority over a compare match in the same cycle.
- R4: While the channel is active, a wrap strobe copies the shadow byte into the working compare byte at that edge.
- R5: For a shadow value H from 1 to 255 that is steady across a period, the output is high for exactly 256 − H of the 256 cycles that follow a wrap. The output first rises after the edge at which the count equals H.
- R6: While the channel is active, a shadow value of 0 makes the wrap edge set the output, so the output is high for all 256 cycles of the period.
- R7: A write to address 1 stores the working compare byte and clears mode bit 0 at the same edge.
- R8: A write to address 2 stores the shadow byte and sets mode bit 0 at the same edge. A shadow write made in the middle of a period leaves that period's duty unchanged and applies from the next wrap.
- R9: The register map is: address 0 holds the mode byte (bit 0 compare enable, bit 1 PWM select, other bits read 0), address 1 holds the working compare byte, address 2 holds the shadow byte, and address 3 reads 0. Read data follows the address in the same cycle.
- R10: After reset, all registers read 0 and the output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_lo | input | 8 | Low byte of the shared timebase count |
| cnt_ovf | input | 1 | One-cycle strobe, high in the cycle the low byte has wrapped to zero |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| pwm_out | output | 1 | PWM output |

## Verification
The output is registered. A match or wrap seen in one cycle therefore shows on pwm_out after that cycle's rising edge. The bench samples on falling edges, so sample i of a period reflects the edge at which the count was i. The wrap-edge reload and register writes also land at the edge, so they are read back from the following falling edge onward. Read data is combinational and is sampled one time unit after the address is driven. Each duty measurement starts at the falling edge that follows the wrap edge and runs for exactly 256 samples. This makes the high count, the first-high index and the low sample just after the period all fall out of the formula directly.

// File: rtl/pwm_ch_pkg.sv
package pwm_ch_pkg;
   typedef enum logic [1:0] {
      REG_MODE   = 2'd0,
      REG_CMP_LO = 2'd1,
      REG_CMP_HI = 2'd2,
      REG_NONE   = 2'd3
   } reg_addr_e;

   localparam int MODE_EN_BIT  = 0;
   localparam int MODE_PWM_BIT = 1;
   localparam int ADDR_W       = 2;
endpackage

// File: rtl/pwm_ch_regs.sv
module pwm_ch_regs
   import pwm_ch_pkg::*;
#(
   parameter int CW = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [CW-1:0]     bus_wdata,
   input  logic              reload,
   output logic              cmp_en,
   output logic              pwm_sel,
   output logic [CW-1:0]     cmp_lo,
   output logic [CW-1:0]     cmp_hi,
   output logic [CW-1:0]     bus_rdata
);
   localparam int PAD_W = CW - 2;

   logic wr_mode, wr_lo, wr_hi;
   logic [CW-1:0] mode_rd;

   assign wr_mode = bus_wr && (bus_addr == REG_MODE);
   assign wr_lo   = bus_wr && (bus_addr == REG_CMP_LO);
   assign wr_hi   = bus_wr && (bus_addr == REG_CMP_HI);

   // Enable bit: explicit mode write, or the side effects of compare writes
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmp_en  <= 1'b0;
         pwm_sel <= 1'b0;
      end else begin
         if (wr_mode) begin
            cmp_en  <= bus_wdata[MODE_EN_BIT];
            pwm_sel <= bus_wdata[MODE_PWM_BIT];
         end else if (wr_lo) begin
            cmp_en <= 1'b0;
         end else if (wr_hi) begin
            cmp_en <= 1'b1;
         end
      end
   end

   // Working compare byte: a bus write wins over the wrap reload
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cmp_lo <= '0;
      else if (wr_lo)  cmp_lo <= bus_wdata;
      else if (reload) cmp_lo <= cmp_hi;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cmp_hi <= '0;
      else if (wr_hi) cmp_hi <= bus_wdata;
   end

   generate
      if (PAD_W > 0) begin : g_pad
         assign mode_rd = {{PAD_W{1'b0}}, pwm_sel, cmp_en};
      end else begin : g_nopad
         assign mode_rd = {pwm_sel, cmp_en};
      end
   endgenerate

   always_comb begin
      unique case (bus_addr)
         REG_MODE:   bus_rdata = mode_rd;
         REG_CMP_LO: bus_rdata = cmp_lo;
         REG_CMP_HI: bus_rdata = cmp_hi;
         default:    bus_rdata = '0;
      endcase
   end

   p_wr_lo_clears_en_r7: assert property (@(posedge clk) disable iff (!rst_n)
      wr_lo |=> !cmp_en);
   p_wr_hi_sets_en_r8: assert property (@(posedge clk) disable iff (!rst_n)
      wr_hi |=> cmp_en);
   p_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (reload && !wr_lo) |=> (cmp_lo == $past(cmp_hi)));
   p_no_reload_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!reload && !wr_lo) |=> $stable(cmp_lo));
endmodule

// File: rtl/pwm_ch_core.sv
module pwm_ch_core #(
   parameter int CW           = 8,
   parameter bit FULL_AT_ZERO = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          active,
   input  logic [CW-1:0] cnt_lo,
   input  logic          cnt_ovf,
   input  logic [CW-1:0] cmp_lo,
   input  logic [CW-1:0] cmp_hi,
   output logic          pwm_out
);
   logic match;
   logic wrap_level;

   assign match = (cnt_lo == cmp_lo);

   // Level the output takes at a wrap; the zero-duty-word variant stays high
   generate
      if (FULL_AT_ZERO) begin : g_full
         assign wrap_level = (cmp_hi == '0);
      end else begin : g_plain
         assign wrap_level = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       pwm_out <= 1'b0;
      else if (!active) pwm_out <= 1'b0;
      else if (cnt_ovf) pwm_out <= wrap_level;
      else if (match)   pwm_out <= 1'b1;
   end

   p_match_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (active && !cnt_ovf && match) |=> pwm_out);
   p_hold_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (active && !cnt_ovf && pwm_out) |=> pwm_out);
   p_wrap_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (active && cnt_ovf && (cmp_hi != '0)) |=> !pwm_out);
   p_off_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !active |=> !pwm_out);
   generate
      if (FULL_AT_ZERO) begin : g_zchk
         p_zero_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (active && cnt_ovf && (cmp_hi == '0)) |=> pwm_out);
      end
   endgenerate
endmodule

// File: rtl/pwm8_channel.sv
module pwm8_channel
   import pwm_ch_pkg::*;
#(
   parameter int CW           = 8,
   parameter bit FULL_AT_ZERO = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CW-1:0]     cnt_lo,
   input  logic              cnt_ovf,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [CW-1:0]     bus_wdata,
   output logic [CW-1:0]     bus_rdata,
   output logic              pwm_out
);
   generate
      if (CW < 2) begin : g_bad_cw
         $fatal(1, "pwm8_channel: CW must be at least 2 for the mode byte");
      end
   endgenerate

   logic          cmp_en, pwm_sel, active;
   logic [CW-1:0] cmp_lo, cmp_hi;

   assign active = cmp_en && pwm_sel;

   pwm_ch_regs #(.CW(CW)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_wr    (bus_wr),
      .bus_wdata (bus_wdata),
      .reload    (active && cnt_ovf),
      .cmp_en    (cmp_en),
      .pwm_sel   (pwm_sel),
      .cmp_lo    (cmp_lo),
      .cmp_hi    (cmp_hi),
      .bus_rdata (bus_rdata)
   );

   pwm_ch_core #(.CW(CW), .FULL_AT_ZERO(FULL_AT_ZERO)) u_core (
      .clk     (clk),
      .rst_n   (rst_n),
      .active  (active),
      .cnt_lo  (cnt_lo),
      .cnt_ovf (cnt_ovf),
      .cmp_lo  (cmp_lo),
      .cmp_hi  (cmp_hi),
      .pwm_out (pwm_out)
   );
endmodule

// File: tb/sim_pwm8_channel.sv
`timescale 1ns/1ps
module sim_pwm8_channel;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       run = 1'b0;
   logic [7:0] cnt_lo = 8'd0;
   logic       cnt_ovf;
   logic [1:0] bus_addr = 2'd0;
   logic       bus_wr = 1'b0;
   logic [7:0] bus_wdata = 8'd0;
   logic [7:0] bus_rdata;
   logic       pwm_out;

   int errors = 0;
   int checks = 0;

   always #2.5 clk = ~clk;

   always @(posedge clk) if (run) cnt_lo <= cnt_lo + 8'd1;
   assign cnt_ovf = run && (cnt_lo == 8'd0);

   pwm8_channel u0 (
      .clk(clk), .rst_n(rst_n), .cnt_lo(cnt_lo), .cnt_ovf(cnt_ovf),
      .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .pwm_out(pwm_out)
   );

   // shadow value, expected high cycles
   localparam int NV = 5;
   localparam int VEC [NV][2] = '{
      '{0, 256}, '{1, 255}, '{128, 128}, '{255, 1}, '{64, 192}
   };

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [1:0] a, output int v);
      bus_addr = a;
      #1;
      v = bus_rdata;
   endtask

   task automatic wait_ovf();
      do @(negedge clk); while (!cnt_ovf);
   endtask

   // 256 samples after a wrap edge; optional shadow write at sample wr_at
   task automatic measure(input int wr_at, input logic [7:0] wv,
                          output int hi, output int first);
      hi = 0; first = -1;
      for (int i = 0; i < 256; i++) begin
         @(negedge clk);
         if (pwm_out) begin
            hi++;
            if (first < 0) first = i;
         end
         if (i == wr_at) begin
            bus_addr = 2'd2; bus_wdata = wv; bus_wr = 1'b1;
         end else begin
            bus_wr = 1'b0;
         end
      end
   endtask

   initial begin
      #(200000 * 5);
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      int v, hi, first;
      repeat (3) @(negedge clk);
      // R10 reset state
      chk("R10 out", pwm_out, 0);
      bus_read(2'd0, v); chk("R10 mode", v, 0);
      bus_read(2'd1, v); chk("R10 lo", v, 0);
      bus_read(2'd2, v); chk("R10 hi", v, 0);
      rst_n = 1'b1;
      @(negedge clk);
      run = 1'b1;

      bus_write(2'd0, 8'hFF);
      bus_read(2'd0, v); chk("R9 mode bits", v, 3);
      bus_read(2'd3, v); chk("R9 addr3", v, 0);

      // table sweep
      for (int k = 0; k < NV; k++) begin
         bus_write(2'd2, 8'(VEC[k][0]));
         bus_read(2'd2, v); chk("R9 hi readback", v, VEC[k][0]);
         wait_ovf();
         measure(-1, 8'd0, hi, first);
         chk(VEC[k][0] == 0 ? "R6 duty" : "R5 duty", hi, VEC[k][1]);
         if (VEC[k][0] != 0) begin
            chk("R2 first high", first, VEC[k][0]);
            @(negedge clk);
            chk("R3 low after wrap", pwm_out, 0);
         end
         bus_read(2'd1, v); chk("R4 reload", v, VEC[k][0]);
      end

      // R8 mid-period shadow update
      bus_write(2'd2, 8'd128);
      wait_ovf();
      measure(10, 8'd200, hi, first);
      chk("R8 current period", hi, 128);
      measure(-1, 8'd0, hi, first);
      chk("R8 next period", hi, 56);

      // R7 low-byte write disables
      bus_write(2'd1, 8'h40);
      bus_read(2'd0, v); chk("R7 en cleared", v, 2);
      bus_read(2'd1, v); chk("R7 lo stored", v, 8'h40);
      wait_ovf();
      measure(-1, 8'd0, hi, first);
      chk("R1 disabled duty", hi, 0);
      bus_read(2'd1, v); chk("R1 no reload", v, 8'h40);

      // R8 high write re-enables
      bus_write(2'd2, 8'h10);
      bus_read(2'd0, v); chk("R8 en set", v, 3);
      wait_ovf();
      measure(-1, 8'd0, hi, first);
      chk("R5 duty 0x10", hi, 240);

      // R1 PWM select off
      bus_write(2'd0, 8'h01);
      bus_write(2'd2, 8'h80);
      wait_ovf();
      measure(-1, 8'd0, hi, first);
      chk("R1 pwm off duty", hi, 0);
      bus_read(2'd1, v); chk("R1 pwm off no reload", v, 8'h10);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule